// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Distributor

This block keeps one shared 64-bit vector of pending device requests and hands them out to four processors. Each processor has its own 64-bit enable mask and its own 64-bit latched result. A processor's level interrupt rises the first time a masked request lands in its result. It then stays high until clears have emptied that result. Devices set and remove pending bits with one-cycle vector strobes. Software changes a processor's mask through a small register write port with a select and a data word.

A small legacy front end sits in front of one request line. It has an 8-bit pending vector and an 8-bit enable mask. When the enabled pending set becomes non-empty, it posts request bit 55 of the shared vector once per episode. When a front-end clear empties the enabled set, it removes that bit. A second front-end mask register can be written, but it only stores its value and never affects any interrupt.

Top module: `irq_distributor`

## Requirements
- R1: After reset every processor interrupt is low, and all pending, mask, result and flag state is zero, so a mask write right after reset raises nothing.
- R2: A device post whose vector overlaps processor N's mask raises irq bit N after the next rising edge. Processors whose masks do not overlap stay low.
- R3: Posted bits accumulate in a processor's result. A clear that removes only some of its result bits leaves its interrupt high.
- R4: A clear that leaves a processor's result empty drops its interrupt after that edge. A clear of bits that are not in its result leaves a high interrupt high.
- R5: When a post and a clear name the same bit in one cycle, the clear wins. The bit is neither pending nor delivered.
- R6: Writing processor N's mask (select value N, N in 0..3) while mask AND pending is non-zero replaces N's result with that intersection and raises its interrupt. A mask write in the same cycle as a post sees that post.
- R7: A mask write whose intersection with pending is empty leaves the result and interrupt unchanged. A high interrupt stays high until a later clear empties the old result.
- R8: The front end posts shared bit 55 when its pending AND mask A becomes non-zero, on a front-end post or a mask A write (select value 4, data bits 7:0). The processor interrupt follows two edges after the causing input.
- R9: A front-end clear that leaves pending AND mask A empty removes shared bit 55, two edges later. A mask A write that empties the intersection removes nothing.
- R10: Writing mask B (select value 5) stores the value and never produces an interrupt.
- R11: While the front end is in an active episode, further front-end posts do not post bit 55 again. Only after a front-end clear has ended the episode can bit 55 be posted anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_post_valid | input | 1 | Device post strobe |
| dev_post_vec | input | 64 | Bits to set in the shared pending vector |
| dev_clear_valid | input | 1 | Device clear strobe |
| dev_clear_vec | input | 64 | Bits to remove from pending and from every result |
| pic_post_valid | input | 1 | Front-end post strobe |
| pic_post_vec | input | 8 | Bits to set in the front-end pending vector |
| pic_clear_valid | input | 1 | Front-end clear strobe |
| pic_clear_vec | input | 8 | Bits to remove from the front-end pending vector |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_sel | input | 3 | 0..3 processor mask, 4 front-end mask A, 5 front-end mask B |
| cfg_wdata | input | 64 | Write data; the front-end masks use bits 7:0 |
| cpu_irq | output | 4 | Level interrupt per processor |

## Verification
The hardest states to reach are those where the result no longer equals mask AND pending. This happens after a mask write replaces a result while other bits are still pending. It also happens when the shared bit 55 was cleared directly while the front end still considers its episode open. The bench builds both on purpose. It posts a bit, moves the mask onto another pending bit and clears only that one, expecting the interrupt to drop. It also clears bit 55 with a device clear, then re-posts into the still-active front end and expects silence until a front-end clear ends the episode. A full sweep of every bit against every processor covers the routing.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned CFG_SEL_W  = 3;
  localparam int unsigned SEL_PIC_A  = 4;
  localparam int unsigned SEL_PIC_B  = 5;
endpackage

// File: rtl/irq_pic_front.sv
module irq_pic_front #(
  parameter int unsigned PIC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid,
  input  logic [PIC_W-1:0] post_vec,
  input  logic             clear_valid,
  input  logic [PIC_W-1:0] clear_vec,
  input  logic             mask_a_we,
  input  logic             mask_b_we,
  input  logic [PIC_W-1:0] mask_wdata,
  output logic             sum_post_o,
  output logic             sum_clear_o
);
  logic [PIC_W-1:0] raw_q, raw_d;
  logic [PIC_W-1:0] mask_a_q, mask_a_d;
  logic [PIC_W-1:0] mask_b_q;
  logic             flag_q, flag_d;
  logic             sum_post_q, sum_clear_q;
  logic             active_d, raise, drop;
  logic [PIC_W-1:0] post_eff, clr_eff;
  logic             raw_en;

  always_comb begin
    post_eff = post_valid  ? post_vec  : '0;
    clr_eff  = clear_valid ? clear_vec : '0;
    raw_en   = post_valid | clear_valid;
    raw_d    = (raw_q | post_eff) & ~clr_eff;
    mask_a_d = mask_a_we ? mask_wdata : mask_a_q;
    active_d = |(raw_d & mask_a_d);
    raise    = (post_valid | mask_a_we) & active_d & ~flag_q;
    drop     = clear_valid & ~active_d;
    if (raise)     flag_d = 1'b1;
    else if (drop) flag_d = 1'b0;
    else           flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q       <= '0;
      mask_a_q    <= '0;
      mask_b_q    <= '0;
      flag_q      <= 1'b0;
      sum_post_q  <= 1'b0;
      sum_clear_q <= 1'b0;
    end else begin
      if (raw_en)    raw_q    <= raw_d;
      if (mask_a_we) mask_a_q <= mask_a_d;
      if (mask_b_we) mask_b_q <= mask_wdata;
      flag_q      <= flag_d;
      sum_post_q  <= raise;
      sum_clear_q <= drop;
    end
  end

  assign sum_post_o  = sum_post_q;
  assign sum_clear_o = sum_clear_q;

  // R11: an open episode never posts the summary bit again
  a_r11_no_repost: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> !sum_post_q);
  // R9: a summary clear leaves the episode closed
  a_r9_clear_closes: assert property (@(posedge clk) disable iff (!rst_n)
    sum_clear_q |-> !flag_q);
  // R10: writing mask B alone causes no post
  a_r10_mask_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_b_we && !mask_a_we && !post_valid) |=> !sum_post_q);
  // R10: mask B only changes on its own write
  a_r10_mask_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_b_we |=> $stable(mask_b_q));
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int unsigned VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid,
  input  logic [VEC_W-1:0] post_vec,
  input  logic             clear_valid,
  input  logic [VEC_W-1:0] clear_vec,
  input  logic [VEC_W-1:0] raw_next,
  input  logic             mask_we,
  input  logic [VEC_W-1:0] mask_wdata,
  output logic             irq_o
);
  logic [VEC_W-1:0] mask_q, mask_d;
  logic [VEC_W-1:0] res_q, res_d, res_pc, hit_post, isect;
  logic [VEC_W-1:0] post_eff, clr_eff;
  logic             flag_q, flag_d;
  logic             raise_post, raise_wr, res_en;

  always_comb begin
    post_eff   = post_valid  ? post_vec  : '0;
    clr_eff    = clear_valid ? clear_vec : '0;
    hit_post   = post_eff & mask_q & ~clr_eff;
    res_pc     = (res_q | hit_post) & ~clr_eff;
    mask_d     = mask_we ? mask_wdata : mask_q;
    isect      = mask_d & raw_next;
    raise_wr   = mask_we & (|isect);
    raise_post = |hit_post;
    res_d      = raise_wr ? isect : res_pc;
    res_en     = post_valid | clear_valid | mask_we;
    if (raise_post || raise_wr)              flag_d = 1'b1;
    else if (clear_valid && (res_d == '0))   flag_d = 1'b0;
    else                                     flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (res_en)  res_q  <= res_d;
      flag_q <= flag_d;
    end
  end

  assign irq_o = flag_q;

  // R3: the interrupt level follows whether the result holds any bit
  a_r3_level_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q == (res_q != '0));
  // R2: an overlapping surviving post raises the interrupt
  a_r2_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && ((post_vec & mask_q & ~(clear_valid ? clear_vec : '0)) != '0)) |=> irq_o);
  // R7: a mask write without a clear never lowers the interrupt
  a_r7_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !clear_valid && irq_o) |=> irq_o);
  // R4: with no post and no mask write a low interrupt stays low
  a_r4_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_valid && !mask_we && !irq_o) |=> !irq_o);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned VEC_W   = 64,
  parameter int unsigned PIC_W   = 8,
  parameter int unsigned PIC_BIT = 55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dev_post_valid,
  input  logic [VEC_W-1:0]     dev_post_vec,
  input  logic                 dev_clear_valid,
  input  logic [VEC_W-1:0]     dev_clear_vec,
  input  logic                 pic_post_valid,
  input  logic [PIC_W-1:0]     pic_post_vec,
  input  logic                 pic_clear_valid,
  input  logic [PIC_W-1:0]     pic_clear_vec,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [VEC_W-1:0]     cfg_wdata,
  output logic [NUM_CPU-1:0]   cpu_irq
);
  localparam logic [VEC_W-1:0] PIC_ONEHOT = {{(VEC_W-1){1'b0}}, 1'b1} << PIC_BIT;

  logic             sum_post, sum_clear;
  logic             post_v, clear_v;
  logic [VEC_W-1:0] post_eff, clr_eff;
  logic [VEC_W-1:0] raw_q, raw_d;
  logic             pic_a_we, pic_b_we;

  assign pic_a_we = cfg_we && (cfg_sel == CFG_SEL_W'(SEL_PIC_A));
  assign pic_b_we = cfg_we && (cfg_sel == CFG_SEL_W'(SEL_PIC_B));

  irq_pic_front #(.PIC_W(PIC_W)) u_pic (
    .clk         (clk),
    .rst_n       (rst_n),
    .post_valid  (pic_post_valid),
    .post_vec    (pic_post_vec),
    .clear_valid (pic_clear_valid),
    .clear_vec   (pic_clear_vec),
    .mask_a_we   (pic_a_we),
    .mask_b_we   (pic_b_we),
    .mask_wdata  (cfg_wdata[PIC_W-1:0]),
    .sum_post_o  (sum_post),
    .sum_clear_o (sum_clear)
  );

  always_comb begin
    post_v   = dev_post_valid | sum_post;
    clear_v  = dev_clear_valid | sum_clear;
    post_eff = (dev_post_valid ? dev_post_vec : '0) | (sum_post ? PIC_ONEHOT : '0);
    clr_eff  = (dev_clear_valid ? dev_clear_vec : '0) | (sum_clear ? PIC_ONEHOT : '0);
    raw_d    = (raw_q | post_eff) & ~clr_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                raw_q <= '0;
    else if (post_v | clear_v) raw_q <= raw_d;
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    irq_cpu_port #(.VEC_W(VEC_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .post_valid  (post_v),
      .post_vec    (post_eff),
      .clear_valid (clear_v),
      .clear_vec   (clr_eff),
      .raw_next    (raw_d),
      .mask_we     (cfg_we && (cfg_sel == CFG_SEL_W'(i))),
      .mask_wdata  (cfg_wdata),
      .irq_o       (cpu_irq[i])
    );
  end

  // R5: a cleared bit is never left pending, even when posted in the same cycle
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clear_valid |=> ((raw_q & $past(dev_clear_vec)) == '0));
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_post_valid = 1'b0, dev_clear_valid = 1'b0;
  logic [63:0] dev_post_vec = '0, dev_clear_vec = '0;
  logic        pic_post_valid = 1'b0, pic_clear_valid = 1'b0;
  logic [7:0]  pic_post_vec = '0, pic_clear_vec = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic [3:0]  cpu_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] B55 = 64'd1 << 55;

  always #2 clk = ~clk;

  irq_distributor u_dut (
    .clk(clk), .rst_n(rst_n),
    .dev_post_valid(dev_post_valid), .dev_post_vec(dev_post_vec),
    .dev_clear_valid(dev_clear_valid), .dev_clear_vec(dev_clear_vec),
    .pic_post_valid(pic_post_valid), .pic_post_vec(pic_post_vec),
    .pic_clear_valid(pic_clear_valid), .pic_clear_vec(pic_clear_vec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_irq(cpu_irq)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    dev_post_valid = 1'b0; dev_clear_valid = 1'b0;
    pic_post_valid = 1'b0; pic_clear_valid = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (cpu_irq !== exp) begin
      errors++;
      $display("FAIL %s cpu_irq=%b expected=%b", req, cpu_irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cyc();
  endtask
  task automatic post(input logic [63:0] v);
    dev_post_valid = 1'b1; dev_post_vec = v; cyc();
  endtask
  task automatic clr(input logic [63:0] v);
    dev_clear_valid = 1'b1; dev_clear_vec = v; cyc();
  endtask
  task automatic ppost(input logic [7:0] v);
    pic_post_valid = 1'b1; pic_post_vec = v; cyc();
  endtask
  task automatic pclr(input logic [7:0] v);
    pic_clear_valid = 1'b1; pic_clear_vec = v; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 4'b0000);
    wr(3'd0, '1);
    chk("R1 empty pending after reset", 4'b0000);
    wr(3'd0, '0);

    // R2 sweep: every bit routed to every processor
    for (int b = 0; b < 64; b++) begin
      for (int c = 0; c < 4; c++) begin
        wr(3'(c), 64'd1 << b);
        post(64'd1 << b);
        chk("R2 route", 4'(1 << c));
        clr(64'd1 << b);
        chk("R4 sweep drop", 4'b0000);
        wr(3'(c), '0);
      end
    end

    // R3 / R4 accumulation and partial clears
    wr(3'd0, 64'h3);
    wr(3'd1, 64'h2);
    post(64'h1);
    chk("R3 first post", 4'b0001);
    post(64'h2);
    chk("R3 accumulate", 4'b0011);
    clr(64'h40);
    chk("R4 unrelated clear", 4'b0011);
    clr(64'h1);
    chk("R3 partial clear", 4'b0011);
    clr(64'h2);
    chk("R4 empty result", 4'b0000);
    wr(3'd0, '0);
    wr(3'd1, '0);

    // R5 clear wins
    wr(3'd2, 64'h10);
    dev_post_valid = 1'b1; dev_post_vec = 64'h10;
    dev_clear_valid = 1'b1; dev_clear_vec = 64'h10;
    cyc();
    chk("R5 same-cycle post and clear", 4'b0000);
    wr(3'd2, 64'h10);
    chk("R5 bit not pending", 4'b0000);
    wr(3'd2, '0);

    // R6 mask write raises, replaces result, sees same-cycle post
    post(64'h100);
    chk("R6 unmasked post", 4'b0000);
    wr(3'd3, 64'h100);
    chk("R6 mask write raises", 4'b1000);
    post(64'h200);
    wr(3'd3, 64'h200);
    chk("R6 replace keeps high", 4'b1000);
    clr(64'h200);
    chk("R6 replaced result emptied", 4'b0000);
    clr(64'h100);
    wr(3'd3, '0);
    dev_post_valid = 1'b1; dev_post_vec = 64'h400;
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 64'h400;
    cyc();
    chk("R6 mask after same-cycle post", 4'b0010);
    clr(64'h400);
    chk("R6 cleanup", 4'b0000);
    wr(3'd1, '0);

    // R7 mask write with empty intersection
    wr(3'd0, 64'h8);
    post(64'h8);
    chk("R7 setup", 4'b0001);
    wr(3'd0, 64'h0);
    chk("R7 zero mask keeps level", 4'b0001);
    wr(3'd0, 64'h20);
    chk("R7 disjoint mask keeps level", 4'b0001);
    clr(64'h8);
    chk("R7 clear old result", 4'b0000);
    wr(3'd0, '0);

    // R8 front-end summary into bit 55
    wr(3'd1, B55);
    ppost(8'h04);
    cyc();
    chk("R8 masked front-end post", 4'b0000);
    wr(3'd4, 64'h04);
    chk("R8 latency first edge", 4'b0000);
    cyc();
    chk("R8 mask A write raises", 4'b0010);

    // R9 summary clear
    wr(3'd4, 64'h00);
    cyc();
    chk("R9 mask A zero keeps bit", 4'b0010);
    pclr(8'h04);
    chk("R9 latency first edge", 4'b0010);
    cyc();
    chk("R9 front-end clear drops", 4'b0000);

    // R11 one post per episode
    wr(3'd4, 64'h01);
    ppost(8'h01);
    cyc();
    chk("R11 episode start", 4'b0010);
    clr(B55);
    chk("R11 bit 55 cleared directly", 4'b0000);
    ppost(8'h01);
    cyc();
    chk("R11 no repost in episode", 4'b0000);
    pclr(8'h01);
    cyc();
    ppost(8'h01);
    cyc();
    chk("R11 repost after episode end", 4'b0010);
    pclr(8'h01);
    cyc();
    chk("R11 cleanup", 4'b0000);

    // R10 mask B never interrupts
    ppost(8'h80);
    cyc();
    chk("R10 inactive pending", 4'b0000);
    wr(3'd5, 64'hFF);
    cyc();
    chk("R10 mask B write", 4'b0000);
    wr(3'd4, 64'h80);
    cyc();
    chk("R10 pending was present", 4'b0010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule